// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block sits between a set of external interrupt wires and a message fabric. Every input pin has its own redirection entry. The entry sets whether the pin is masked, which level counts as active, whether the pin is edge- or level-sensitive, and the delivery mode, destination addressing and vector to send. When an unmasked pin becomes active, the block queues a request for that pin. A round-robin arbiter then picks one pending pin and presents its message on a valid/ready output port.

Software programs the entries through a two-register window: an 8-bit index register and a 32-bit data register. Two states are visible in the entry but cannot be written. Delivery status shows a request that has been raised but not yet accepted. The remote request flag shows a level-sensitive message that was accepted and has not yet been retired by an end-of-interrupt (EOI) with a matching vector.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every entry's low word reads 0x0001_0000 (masked, all other fields zero), every high word reads 0, and `msg_valid` is low.
- R2: Index 0x10+2n reaches the low word of entry n and index 0x10+2n+1 reaches its high word. Low-word bits: [7:0] vector, [10:8] delivery mode, [11] logical addressing, [12] delivery status (read-only), [13] active-low polarity, [14] remote request (read-only), [15] level trigger, [16] mask. The high word holds the destination in [31:24]. All other bits read as zero.
- R3: An unmasked edge-mode pin produces one message for each active edge, seen after a two-flop synchronizer. The active edge is a rise when bit 13 is 0 and a fall when it is 1. The message carries the vector, mode, addressing bit, destination and a level flag.
- R4: Delivery modes 010, 100 and 101 are handled as edge-triggered even when bit 15 is set. Their messages carry level flag 0 and never set the remote request flag.
- R5: In modes 010 and 100 the message vector is 0, whatever value is programmed.
- R6: An edge on a masked pin is dropped completely. No message is sent, delivery status stays 0, and clearing the mask later produces nothing.
- R7: Delivery status reads 1 while a request waits on a stalled port, and 0 once the message has been accepted. Writing the low word does not change it.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and the message fields stay constant.
- R9: A level-mode pin (bit 15 set, mode not 010, 100 or 101) sends a message with level flag 1 while it is active. On acceptance it sets the remote request flag. While the flag is set, the pin's active level sends nothing more.
- R10: An EOI whose vector equals the entry's vector clears the remote request flag, and an EOI with any other vector leaves it set. If the pin is still active once the flag clears, a new message is sent.
- R11: Among pending pins, the grant goes to the first pin at or above the one after the last accepted pin, wrapping from the last pin to pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Load the index register |
| idx_wdata | input | 8 | New index value |
| data_we | input | 1 | Write the data word at the current index |
| data_wdata | input | 32 | Data word to write |
| data_rdata | output | 32 | Data word at the current index |
| irq_pins | input | 24 | Asynchronous interrupt inputs |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Destination is a logical set |
| msg_dest | output | 8 | Destination |
| msg_level | output | 1 | Message is level-triggered |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |

## Verification
A table walks six pins through the fixed, lowest-priority, SMI, NMI, INIT and external modes. It mixes the two polarities and the two addressing kinds, and sets the trigger bit on the forced-edge modes, so that vector blanking and the forced level flag can be told apart from the programmed fields. Directed sequences cover the rest. An edge on a masked pin must be dropped. A stall must hold the pending status through a rewrite of the entry. A held level must be gated by the remote flag, first against a wrong-vector EOI and then against a matching one. Two simultaneous bursts of requests must be served in an order that shows the rotating start point rather than a fixed priority.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    localparam int unsigned VEC_W  = 8;
    localparam int unsigned DEST_W = 8;
    localparam int unsigned WORD_W = 32;

    localparam int unsigned B_MODE_LO = 8;
    localparam int unsigned B_LOGICAL = 11;
    localparam int unsigned B_STATUS  = 12;
    localparam int unsigned B_POL     = 13;
    localparam int unsigned B_RIRR    = 14;
    localparam int unsigned B_TRIG    = 15;
    localparam int unsigned B_MASK    = 16;
    localparam int unsigned B_DEST_LO = 24;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV3   = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_RSV6   = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trig_lvl;
        logic              pol_low;
        logic              logical;
        dmode_e            mode;
        logic [VEC_W-1:0]  vector;
    } rte_cfg_t;

    localparam rte_cfg_t CFG_RESET = '{dest: '0, mask: 1'b1, trig_lvl: 1'b0,
                                       pol_low: 1'b0, logical: 1'b0,
                                       mode: DM_FIXED, vector: '0};

    function automatic logic forced_edge(dmode_e m);
        return (m == DM_SMI) || (m == DM_NMI) || (m == DM_INIT);
    endfunction

    function automatic logic vector_dropped(dmode_e m);
        return (m == DM_SMI) || (m == DM_NMI);
    endfunction

    function automatic logic [WORD_W-1:0] pack_lo(rte_cfg_t c, logic pend, logic rirr);
        logic [WORD_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]             = c.vector;
        w[B_MODE_LO+2:B_MODE_LO] = c.mode;
        w[B_LOGICAL]             = c.logical;
        w[B_STATUS]              = pend;
        w[B_POL]                 = c.pol_low;
        w[B_RIRR]                = rirr;
        w[B_TRIG]                = c.trig_lvl;
        w[B_MASK]                = c.mask;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_hi(rte_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_DEST_LO+DEST_W-1:B_DEST_LO] = c.dest;
        return w;
    endfunction

endpackage

// File: rtl/irq_pin_slice.sv
`timescale 1ns/1ps
module irq_pin_slice
    import irq_route_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_raw,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                accept,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vector,
    output rte_cfg_t            cfg,
    output logic                pending,
    output logic                rirr,
    output logic                level_mode
);

    rte_cfg_t               cfg_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   act, act_q;
    logic                   pend_q, rirr_q;
    logic                   edge_set, level_set, eoi_hit;

    always_comb begin
        act        = sync_q[SYNC_STAGES-1] ^ cfg_q.pol_low;
        level_mode = cfg_q.trig_lvl & ~forced_edge(cfg_q.mode);
        edge_set   = ~level_mode & ~cfg_q.mask & act & ~act_q;
        level_set  = level_mode & ~cfg_q.mask & act & ~rirr_q;
        eoi_hit    = eoi_valid & (eoi_vector == cfg_q.vector);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            sync_q <= '0;
            act_q  <= 1'b0;
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
            act_q  <= act;
            if (wr_lo) begin
                cfg_q.vector   <= wdata[VEC_W-1:0];
                cfg_q.mode     <= dmode_e'(wdata[B_MODE_LO+2:B_MODE_LO]);
                cfg_q.logical  <= wdata[B_LOGICAL];
                cfg_q.pol_low  <= wdata[B_POL];
                cfg_q.trig_lvl <= wdata[B_TRIG];
                cfg_q.mask     <= wdata[B_MASK];
            end
            if (wr_hi) begin
                cfg_q.dest <= wdata[B_DEST_LO+DEST_W-1:B_DEST_LO];
            end
            if (accept) pend_q <= edge_set;
            else        pend_q <= pend_q | edge_set | level_set;
            rirr_q <= (accept & level_mode) | (rirr_q & ~eoi_hit);
        end
    end

    assign cfg     = cfg_q;
    assign pending = pend_q;
    assign rirr    = rirr_q;

endmodule

// File: rtl/irq_rr_arb.sv
`timescale 1ns/1ps
module irq_rr_arb #(
    parameter int N = 24,
    localparam int GW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          ready,
    output logic          valid,
    output logic [GW-1:0] gnt
);

    logic [GW-1:0] ptr_q, held_q, pick;
    logic          lock_q, found;

    always_comb begin
        int j;
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            j = int'(ptr_q) + i;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = GW'(j);
            end
        end
        valid = lock_q | found;
        gnt   = lock_q ? held_q : pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            held_q <= '0;
            lock_q <= 1'b0;
        end else if (valid && ready) begin
            ptr_q  <= (gnt == GW'(N-1)) ? '0 : gnt + 1'b1;
            lock_q <= 1'b0;
        end else if (valid) begin
            lock_q <= 1'b1;
            held_q <= gnt;
        end
    end

endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int          NUM_PINS    = 24,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  IDX_BASE    = 8'h10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idx_we,
    input  logic [7:0]          idx_wdata,
    input  logic                data_we,
    input  logic [31:0]         data_wdata,
    output logic [31:0]         data_rdata,
    input  logic [NUM_PINS-1:0] irq_pins,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_mode,
    output logic                msg_logical,
    output logic [7:0]          msg_dest,
    output logic                msg_level,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector
);

    localparam int GW    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int IDX_W = 8;

    logic [IDX_W-1:0]    idx_q, rel;
    logic [IDX_W-2:0]    ent_sel;
    logic                in_range;
    rte_cfg_t            cfg_a [NUM_PINS];
    logic [NUM_PINS-1:0] pend_v, rirr_v, lvl_v;
    logic [GW-1:0]       gnt;
    rte_cfg_t            cur;

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (idx_we) idx_q <= idx_wdata;
    end

    always_comb begin
        rel      = idx_q - IDX_BASE;
        ent_sel  = rel[IDX_W-1:1];
        in_range = (idx_q >= IDX_BASE) && (int'(rel) < 2 * NUM_PINS);
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic sel;
        assign sel = in_range && (int'(ent_sel) == g);
        irq_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) i_slice (
            .clk        (clk),
            .rst        (rst),
            .pin_raw    (irq_pins[g]),
            .wr_lo      (data_we & sel & ~idx_q[0]),
            .wr_hi      (data_we & sel &  idx_q[0]),
            .wdata      (data_wdata),
            .accept     (msg_valid & msg_ready & (int'(gnt) == g)),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .cfg        (cfg_a[g]),
            .pending    (pend_v[g]),
            .rirr       (rirr_v[g]),
            .level_mode (lvl_v[g])
        );
    end

    always_comb begin
        data_rdata = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (in_range && int'(ent_sel) == i) begin
                data_rdata = idx_q[0] ? pack_hi(cfg_a[i])
                                      : pack_lo(cfg_a[i], pend_v[i], rirr_v[i]);
            end
        end
    end

    irq_rr_arb #(.N(NUM_PINS)) i_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (pend_v),
        .ready (msg_ready),
        .valid (msg_valid),
        .gnt   (gnt)
    );

    always_comb begin
        cur         = cfg_a[gnt];
        msg_vector  = vector_dropped(cur.mode) ? '0 : cur.vector;
        msg_mode    = cur.mode;
        msg_logical = cur.logical;
        msg_dest    = cur.dest;
        msg_level   = lvl_v[gnt];
    end

endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk (
    input logic       clk,
    input logic       rst,
    input logic       msg_valid,
    input logic       msg_ready,
    input logic [7:0] msg_vector,
    input logic [2:0] msg_mode,
    input logic [7:0] msg_dest,
    input logic       msg_level
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !msg_valid);

    p_valid_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> msg_valid);

    p_payload_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=>
            ($stable(msg_vector) && $stable(msg_dest) && $stable(msg_mode)));

    p_vector_blank_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && (msg_mode == 3'b010 || msg_mode == 3'b100)) |-> (msg_vector == 8'h00));

    p_forced_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && (msg_mode == 3'b010 || msg_mode == 3'b100 || msg_mode == 3'b101))
            |-> !msg_level);

endmodule

bind irq_route_ctrl irq_route_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_vector (msg_vector),
    .msg_mode   (msg_mode),
    .msg_dest   (msg_dest),
    .msg_level  (msg_level)
);

// File: tb/test_irq_route_ctrl.sv
`timescale 1ns/1ps
module test_irq_route_ctrl;

    typedef struct packed {
        logic [7:0] pin;
        logic [2:0] mode;
        logic       trig;
        logic       pol;
        logic       logical;
        logic [7:0] vec;
        logic [7:0] dest;
        logic [7:0] exp_vec;
        logic       exp_lvl;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{8'd3,  3'b000, 1'b0, 1'b0, 1'b0, 8'h31, 8'h05, 8'h31, 1'b0},
        '{8'd17, 3'b001, 1'b0, 1'b1, 1'b1, 8'h42, 8'hA5, 8'h42, 1'b0},
        '{8'd0,  3'b010, 1'b1, 1'b0, 1'b0, 8'h55, 8'h00, 8'h00, 1'b0},
        '{8'd23, 3'b100, 1'b1, 1'b0, 1'b0, 8'h66, 8'h03, 8'h00, 1'b0},
        '{8'd9,  3'b101, 1'b1, 1'b1, 1'b1, 8'h77, 8'h0C, 8'h77, 1'b0},
        '{8'd12, 3'b111, 1'b0, 1'b0, 1'b0, 8'h20, 8'h0F, 8'h20, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idx_we = 1'b0, data_we = 1'b0;
    logic [7:0]  idx_wdata = '0;
    logic [31:0] data_wdata = '0, data_rdata;
    logic [23:0] irq_pins = '0;
    logic        msg_valid, msg_ready = 1'b0, msg_logical, msg_level;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_mode;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_route_ctrl i_irq_route_ctrl (
        .clk(clk), .rst(rst), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .irq_pins(irq_pins), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_logical(msg_logical),
        .msg_dest(msg_dest), .msg_level(msg_level),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_idx(logic [7:0] v);
        idx_we = 1'b1; idx_wdata = v;
        tick(1);
        idx_we = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] idx, logic [31:0] d);
        set_idx(idx);
        data_we = 1'b1; data_wdata = d;
        tick(1);
        data_we = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] idx, output logic [31:0] d);
        set_idx(idx);
        d = data_rdata;
    endtask

    function automatic logic [7:0] lo_idx(int pin);
        return 8'(8'h10 + 2 * pin);
    endfunction

    function automatic logic [31:0] lo_word(logic [2:0] mode, logic trig, logic pol,
                                            logic logical, logic [7:0] vec, logic mask);
        return {15'd0, mask, trig, 1'b0, pol, 1'b0, logical, mode, vec};
    endfunction

    task automatic wait_valid(int maxc);
        for (int k = 0; k < maxc && !msg_valid; k++) tick(1);
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        tick(1);
        msg_ready = 1'b0;
    endtask

    task automatic pulse(logic [23:0] m, logic [23:0] act_val);
        logic [23:0] idle;
        idle = irq_pins;
        irq_pins = (idle & ~m) | (act_val & m);
        tick(2);
        irq_pins = idle;
    endtask

    task automatic eoi(logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] lo;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        check("R1 valid", {31'd0, msg_valid}, 32'd0);
        rd_reg(8'h10, rd); check("R1 lo0", rd, 32'h0001_0000);
        rd_reg(8'h3F, rd); check("R1 hi23", rd, 32'h0);

        // R2 field layout and reserved bits
        wr_reg(lo_idx(5), 32'hFFFF_FFFF);
        rd_reg(lo_idx(5), rd); check("R2 lo layout", rd, 32'h0001_AFFF);
        wr_reg(lo_idx(5) + 8'd1, 32'hFFFF_FFFF);
        rd_reg(lo_idx(5) + 8'd1, rd); check("R2 hi layout", rd, 32'hFF00_0000);
        wr_reg(lo_idx(5), 32'h0001_0000);

        // R3 R4 R5 mode table
        for (int t = 0; t < NV; t++) begin
            int p;
            p = int'(TBL[t].pin);
            irq_pins[p] = TBL[t].pol;
            tick(4);
            lo = lo_word(TBL[t].mode, TBL[t].trig, TBL[t].pol, TBL[t].logical, TBL[t].vec, 1'b0);
            wr_reg(lo_idx(p) + 8'd1, {TBL[t].dest, 24'd0});
            wr_reg(lo_idx(p), lo);
            tick(4);
            pulse(24'd1 << p, {24{~TBL[t].pol}});
            wait_valid(20);
            check("R3 R4 R5 message",
                  {11'd0, msg_valid, msg_vector, msg_mode, msg_logical, msg_dest, msg_level},
                  {11'd0, 1'b1, TBL[t].exp_vec, TBL[t].mode, TBL[t].logical, TBL[t].dest, TBL[t].exp_lvl});
            accept();
            tick(2);
            rd_reg(lo_idx(p), rd); check("R4 no remote flag", rd, lo);
            wr_reg(lo_idx(p), lo | 32'h0001_0000);
        end

        // R6 masked edge dropped
        wr_reg(lo_idx(7), 32'h0001_0050);
        tick(3);
        pulse(24'd1 << 7, 24'hFF_FFFF);
        tick(6);
        check("R6 no message", {31'd0, msg_valid}, 32'd0);
        rd_reg(lo_idx(7), rd); check("R6 not pending", rd, 32'h0001_0050);
        wr_reg(lo_idx(7), 32'h0000_0050);
        tick(6);
        check("R6 unmask silent", {31'd0, msg_valid}, 32'd0);
        wr_reg(lo_idx(7), 32'h0001_0050);

        // R7 R8 stall
        wr_reg(lo_idx(2), 32'h0000_0060);
        tick(3);
        pulse(24'd1 << 2, 24'hFF_FFFF);
        tick(6);
        check("R8 held", {23'd0, msg_valid, msg_vector}, {23'd0, 1'b1, 8'h60});
        rd_reg(lo_idx(2), rd); check("R7 status pending", rd, 32'h0000_1060);
        wr_reg(lo_idx(2), 32'h0000_0060);
        rd_reg(lo_idx(2), rd); check("R7 write keeps status", rd, 32'h0000_1060);
        check("R8 still held", {23'd0, msg_valid, msg_vector}, {23'd0, 1'b1, 8'h60});
        accept();
        tick(2);
        rd_reg(lo_idx(2), rd); check("R7 status idle", rd, 32'h0000_0060);
        wr_reg(lo_idx(2), 32'h0001_0060);

        // R9 R10 level with remote flag
        irq_pins[4] = 1'b1;
        tick(4);
        wr_reg(lo_idx(4), 32'h0000_8070);
        wait_valid(20);
        check("R9 level message", {22'd0, msg_valid, msg_vector, msg_level}, {22'd0, 1'b1, 8'h70, 1'b1});
        accept();
        tick(2);
        rd_reg(lo_idx(4), rd); check("R9 remote flag set", rd, 32'h0000_C070);
        tick(8);
        check("R9 gated", {31'd0, msg_valid}, 32'd0);
        eoi(8'h71);
        tick(4);
        rd_reg(lo_idx(4), rd); check("R10 wrong eoi", rd, 32'h0000_C070);
        check("R10 wrong eoi silent", {31'd0, msg_valid}, 32'd0);
        eoi(8'h70);
        wait_valid(20);
        check("R10 redeliver", {22'd0, msg_valid, msg_vector, msg_level}, {22'd0, 1'b1, 8'h70, 1'b1});
        accept();
        irq_pins[4] = 1'b0;
        tick(4);
        eoi(8'h70);
        tick(8);
        check("R10 released silent", {31'd0, msg_valid}, 32'd0);
        rd_reg(lo_idx(4), rd); check("R10 flag cleared", rd, 32'h0000_8070);
        wr_reg(lo_idx(4), 32'h0001_8070);

        // R11 round robin, last accepted pin 4
        wr_reg(lo_idx(1),  32'h0000_0081);
        wr_reg(lo_idx(8),  32'h0000_0088);
        wr_reg(lo_idx(20), 32'h0000_0094);
        tick(3);
        pulse((24'd1 << 1) | (24'd1 << 8) | (24'd1 << 20), 24'hFF_FFFF);
        wait_valid(20);
        check("R11 first", {24'd0, msg_vector}, 32'h88);
        accept();
        check("R11 second", {24'd0, msg_vector}, 32'h94);
        accept();
        check("R11 wrap", {24'd0, msg_vector}, 32'h81);
        accept();
        pulse((24'd1 << 1) | (24'd1 << 20), 24'hFF_FFFF);
        wait_valid(20);
        check("R11 rotated first", {24'd0, msg_vector}, 32'h94);
        accept();
        check("R11 rotated second", {24'd0, msg_vector}, 32'h81);
        accept();
        tick(2);
        check("R11 drained", {31'd0, msg_valid}, 32'd0);

        done = 1;
        summary();
    end

endmodule